// File: doc/BRIEF.md
# Platform Interrupt Hub with Claim and Completion

This block gathers interrupt requests from a parameterised set of sources (31 by default, with source ID 0 reserved) and steers them to a small number of hart contexts (2 by default). Each source has a 3-bit priority. Each context has its own enable vector and a 3-bit threshold, and it drives one interrupt line. That line is high while the context has at least one pending, enabled source whose priority is strictly above the context's threshold.

Software reaches the block through a plain 32-bit register bus, made of an address, a write strobe with write data, and a read strobe with read data. A context services an interrupt in two steps. First it reads its claim register. That read returns the best eligible source ID and clears the source's pending flag. Later it writes the same ID back to the same register. That write completes the interrupt and re-arms the source's gateway. Each source is fixed at build time as level-high or rising-edge through the `SRC_EDGE` parameter.

The register bus carries no stream of data, so it has no valid/ready handshake. It accepts one access per cycle and never stalls. Read data is registered.

Top module: `pirq_hub`

## Requirements
- R1: Source ID 0 does not exist. Its priority reads 0, bit 0 of every enable word reads 0, and a claim read that returns 0 means that no interrupt is available.
- R2: The priority of source n is at byte offset 4*n. Only bits [2:0] are stored, and the upper bits read as 0.
- R3: The enable vector of context c is at 0x2000 + 0x80*c. Source n is bit (n mod 32) of word (n div 32) in that block.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and holds 3 bits. The claim/complete register of context c is 4 bytes above it.
- R5: `irq_o[c]` is high exactly when some source is pending, enabled in context c, and has a priority strictly greater than the threshold of c. A priority of 0 therefore never interrupts, and a threshold of 7 blocks everything.
- R6: A claim read returns the highest-priority eligible source for that context, with ties going to the lowest ID, and clears that source's pending flag. Repeated claims drain the eligible set down to 0.
- R7: A claimed level source does not become pending again until it is completed. After the completion, a source still held high becomes pending again.
- R8: A completion write is ignored if the written ID is not enabled in the writing context.
- R9: An edge source becomes pending only on a rising edge of its input. A source held high across its completion does not become pending again.
- R10: A read of an unmapped address returns 0, and a write to one changes no state.
- R11: `bus_rdata` carries the result in the cycle after `bus_re` and is 0 after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC-1 | Request inputs, bit n for source ID n (IDs 1..NSRC-1) |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (a claim read has side effects) |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
The hardest situation to reach from the ports is a completion that arrives while its source is still disabled in the writing context. The bench claims a source held at a steady level, disables the source in that context, and writes the completion. It then re-enables the source and shows that the line stays low. The only effect a lost completion has is a source stuck in service. A second completion then shows the line rising again. The full drain also sweeps every source at once, with priorities spread so that every level holds several ties. The claim order the bench computes therefore exercises the tie rule across the whole ID range, as well as the different re-arm behaviour of level and edge sources.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PRIO_BASE_A  = 32'h0000_0000;
  localparam int EN_BASE_A    = 32'h0000_2000;
  localparam int EN_STRIDE_A  = 32'h0000_0080;
  localparam int CTL_BASE_A   = 32'h0020_0000;
  localparam int CTL_STRIDE_A = 32'h0000_1000;
  localparam int CLAIM_OFS_A  = 4;
endpackage

// File: rtl/pirq_gateway.sv
module pirq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic claim_i,
  input  logic cmpl_i,
  output logic pend_o
);
  logic prev_q, pend_q, busy_q, fire;

  generate
    if (EDGE) begin : g_edge
      assign fire = req_i & ~prev_q;
    end else begin : g_level
      assign fire = req_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      if (claim_i) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
      end else begin
        if (fire && !pend_q && !busy_q) pend_q <= 1'b1;
        if (cmpl_i) busy_q <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  AST_BUSY_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pend_q); // R7
  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (!pend_q && busy_q)); // R6
  AST_PEND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(req_i)); // R9
endmodule

// File: rtl/pirq_select.sv
module pirq_select #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC-1:0]             pend_i,
  input  logic [NSRC-1:0]             en_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [ID_W-1:0]             id_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (pend_i[n] && en_i[n] && (prio_i[n] > best_p)) begin
        best_p = prio_i[n];
        id_o   = ID_W'(n);
      end
    end
  end

  always_comb begin
    AST_BEST_ELIGIBLE: assert (id_o == '0 ||
      (pend_i[id_o] && en_i[id_o] && prio_i[id_o] > thr_i)); // R5
  end
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26,
  localparam int ID_W  = $clog2(NSRC),
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int NWRD  = (NSRC + 31) / 32,
  localparam int WRD_W = (NWRD > 1) ? $clog2(NWRD) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             we,
  input  logic [31:0]                      wdata,
  input  logic                             re,
  output logic [NSRC-1:0][PRIO_W-1:0]      prio_o,
  output logic [NCTX-1:0][NSRC-1:0]        en_o,
  output logic [NCTX-1:0][PRIO_W-1:0]      thr_o,
  output logic [31:0]                      cfg_rdata,
  output logic                             claim_rd,
  output logic                             cmpl_wr,
  output logic [CTX_W-1:0]                 hit_ctx
);
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC-1:0]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;

  logic              prio_hit, en_hit, thr_hit, clm_hit;
  logic [ID_W-1:0]   prio_idx;
  logic [CTX_W-1:0]  en_ctx;
  logic [WRD_W-1:0]  en_word;

  always_comb begin
    prio_hit = 1'b0;
    en_hit   = 1'b0;
    thr_hit  = 1'b0;
    clm_hit  = 1'b0;
    prio_idx = '0;
    en_ctx   = '0;
    en_word  = '0;
    hit_ctx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < ADDR_W'(PRIO_BASE_A + 4 * NSRC)) begin
        prio_hit = 1'b1;
        prio_idx = addr[ID_W+1:2];
      end
      for (int c = 0; c < NCTX; c++) begin
        for (int w = 0; w < NWRD; w++) begin
          if (addr == ADDR_W'(EN_BASE_A + c * EN_STRIDE_A + 4 * w)) begin
            en_hit  = 1'b1;
            en_ctx  = CTX_W'(c);
            en_word = WRD_W'(w);
          end
        end
        if (addr == ADDR_W'(CTL_BASE_A + c * CTL_STRIDE_A)) begin
          thr_hit = 1'b1;
          hit_ctx = CTX_W'(c);
        end
        if (addr == ADDR_W'(CTL_BASE_A + c * CTL_STRIDE_A + CLAIM_OFS_A)) begin
          clm_hit = 1'b1;
          hit_ctx = CTX_W'(c);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (we) begin
      if (prio_hit && prio_idx != '0) prio_q[prio_idx] <= wdata[PRIO_W-1:0];
      if (en_hit) begin
        for (int n = 1; n < NSRC; n++) begin
          if (WRD_W'(n / 32) == en_word) en_q[en_ctx][n] <= wdata[n % 32];
        end
      end
      if (thr_hit) thr_q[hit_ctx] <= wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (prio_hit) cfg_rdata[PRIO_W-1:0] = prio_q[prio_idx];
    if (en_hit) begin
      for (int n = 0; n < NSRC; n++) begin
        if (WRD_W'(n / 32) == en_word) cfg_rdata[n % 32] = en_q[en_ctx][n];
      end
    end
    if (thr_hit) cfg_rdata[PRIO_W-1:0] = thr_q[hit_ctx];
  end

  assign claim_rd = re && clm_hit;
  assign cmpl_wr  = we && clm_hit;
  assign prio_o   = prio_q;
  assign en_o     = en_q;
  assign thr_o    = thr_q;

  AST_ID0_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q[0] == '0) && (en_q[0][0] == 1'b0)); // R1
endmodule

// File: rtl/pirq_hub.sv
module pirq_hub #(
  parameter int              NSRC     = 32,
  parameter int              NCTX     = 2,
  parameter int              PRIO_W   = 3,
  parameter int              ADDR_W   = 26,
  parameter logic [NSRC-1:0] SRC_EDGE = 32'hAAAA_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:1]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W  = $clog2(NSRC);
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic [NCTX-1:0][NSRC-1:0]   en;
  logic [NCTX-1:0][PRIO_W-1:0] thr;
  logic [31:0]                 cfg_rdata;
  logic                        claim_rd, cmpl_wr;
  logic [CTX_W-1:0]            hit_ctx;
  logic [NSRC-1:0]             pend, claim_v, cmpl_v;
  logic [NCTX-1:0][ID_W-1:0]   best;
  logic [ID_W-1:0]             hit_best;

  pirq_regs #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .re(bus_re), .prio_o(prio), .en_o(en), .thr_o(thr), .cfg_rdata(cfg_rdata),
    .claim_rd(claim_rd), .cmpl_wr(cmpl_wr), .hit_ctx(hit_ctx));

  assign pend[0] = 1'b0;
  generate
    for (genvar n = 1; n < NSRC; n++) begin : g_gw
      pirq_gateway #(.EDGE(SRC_EDGE[n])) u_gw (
        .clk(clk), .rst_n(rst_n), .req_i(src_i[n]),
        .claim_i(claim_v[n]), .cmpl_i(cmpl_v[n]), .pend_o(pend[n]));
    end
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      pirq_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
        .pend_i(pend), .en_i(en[c]), .prio_i(prio), .thr_i(thr[c]), .id_o(best[c]));
      assign irq_o[c] = (best[c] != '0);
    end
  endgenerate

  assign hit_best = best[hit_ctx];

  always_comb begin
    claim_v = '0;
    cmpl_v  = '0;
    if (claim_rd && hit_best != '0) claim_v[hit_best] = 1'b1;
    if (cmpl_wr && bus_wdata < 32'(NSRC) && bus_wdata[ID_W-1:0] != '0 &&
        en[hit_ctx][bus_wdata[ID_W-1:0]])
      cmpl_v[bus_wdata[ID_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (!bus_re)  bus_rdata <= '0;
    else if (claim_rd) bus_rdata <= 32'(hit_best);
    else               bus_rdata <= cfg_rdata;
  end

  AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_v)); // R6
  AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !irq_o[hit_ctx]) |=> (bus_rdata == 32'd0)); // R1
  AST_LIVE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && irq_o[hit_ctx]) |=> (bus_rdata != 32'd0)); // R5
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == 32'd0)); // R11
endmodule

// File: tb/pirq_hub_bench.sv
module pirq_hub_bench;
  localparam int              NSRC = 32;
  localparam int              NCTX = 2;
  localparam logic [NSRC-1:0] EDGE = 32'hAAAA_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:1]   src = '0;
  logic [25:0]       addr = '0;
  logic              we = 1'b0, re = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCTX-1:0]   irq;
  int                n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  pirq_hub #(.NSRC(NSRC), .NCTX(NCTX), .SRC_EDGE(EDGE)) u_pirq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata), .irq_o(irq));

  function automatic logic [25:0] a_prio(int n); return 26'(4 * n); endfunction
  function automatic logic [25:0] a_en(int c); return 26'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [25:0] a_thr(int c); return 26'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [25:0] a_clm(int c); return 26'(32'h20_0004 + 32'h1000 * c); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [25:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [25:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R5 R1 R2: reset state
    chk("R5 reset irq", 32'(irq), 32'd0);
    rd(a_clm(0), d); chk("R1 empty claim", d, 32'd0);
    rd(a_prio(7), d); chk("R2 prio reset", d, 32'd0);

    // R2 R1: priority sweep with junk upper bits
    for (int n = 0; n < NSRC; n++) wr(a_prio(n), 32'hABCD_0000 | 32'(n));
    for (int n = 0; n < NSRC; n++) begin
      rd(a_prio(n), d);
      chk("R2 prio readback", d, (n == 0) ? 32'd0 : 32'(n % 8));
    end
    // R3 R1: enable words
    wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), d); chk("R3 en ctx1", d, 32'hFFFF_FFFE);
    wr(a_en(0), 32'h1234_5679); rd(a_en(0), d); chk("R3 en ctx0", d, 32'h1234_5678);
    // R4 threshold width
    wr(a_thr(1), 32'hFF); rd(a_thr(1), d); chk("R4 thr width", d, 32'd7);
    // R10 unmapped
    wr(26'h1000, 32'hFFFF); rd(26'h1000, d); chk("R10 unmapped gap", d, 32'd0);
    rd(a_en(0) + 26'd4, d); chk("R10 en word1", d, 32'd0);
    rd(26'h20_0008, d); chk("R10 ctl gap", d, 32'd0);
    rd(a_thr(2), d); chk("R10 ctx2", d, 32'd0);
    rd(a_prio(31), d); chk("R10 no side effect", d, 32'd7);
    rd(a_en(1), d); chk("R11 read after reads", d, 32'hFFFF_FFFE);

    wr(a_en(1), 0); wr(a_thr(0), 0); wr(a_thr(1), 0);

    // R6 R5: full drain, prio = n%7+1
    for (int n = 1; n < NSRC; n++) wr(a_prio(n), 32'(n % 7 + 1));
    wr(a_en(0), 32'hFFFF_FFFF);
    src = '1;
    idle(2);
    chk("R5 ctx0 live", 32'(irq[0]), 32'd1);
    chk("R5 ctx1 none enabled", 32'(irq[1]), 32'd0);
    for (int p = 7; p >= 1; p--)
      for (int n = 1; n < NSRC; n++)
        if (n % 7 + 1 == p) begin rd(a_clm(0), d); chk("R6 drain order", d, 32'(n)); end
    rd(a_clm(0), d); chk("R6 drained", d, 32'd0);
    chk("R7 no repend in service", 32'(irq[0]), 32'd0);

    // R7 R9: complete all with inputs still high
    for (int n = 1; n < NSRC; n++) wr(a_clm(0), 32'(n));
    idle(2);
    for (int p = 7; p >= 1; p--)
      for (int n = 1; n < NSRC; n++)
        if (n % 7 + 1 == p && !EDGE[n]) begin
          rd(a_clm(0), d); chk("R7 level rearm / R9 edge quiet", d, 32'(n));
        end
    rd(a_clm(0), d); chk("R9 no edge repend", d, 32'd0);
    src = '0;
    for (int n = 1; n < NSRC; n++) wr(a_clm(0), 32'(n));
    idle(2);
    chk("R7 all idle", 32'(irq), 32'd0);

    // R9: edge source 19
    src[19] = 1'b1; idle(2);
    chk("R9 rising edge", 32'(irq[0]), 32'd1);
    rd(a_clm(0), d); chk("R9 claim edge", d, 32'd19);
    wr(a_clm(0), 19); idle(2);
    chk("R9 held high stays quiet", 32'(irq[0]), 32'd0);
    src[19] = 1'b0; idle(1); src[19] = 1'b1; idle(2);
    chk("R9 new edge", 32'(irq[0]), 32'd1);
    rd(a_clm(0), d); chk("R9 claim again", d, 32'd19);
    wr(a_clm(0), 19); src = '0; idle(2);

    // R5: threshold sweep on ctx1 with source 3 at prio 4
    wr(a_en(1), 32'h8); wr(a_prio(3), 4); src[3] = 1'b1;
    for (int t = 0; t < 8; t++) begin
      wr(a_thr(1), 32'(t)); idle(1);
      chk("R5 threshold sweep", 32'(irq[1]), (4 > t) ? 32'd1 : 32'd0);
    end
    wr(a_thr(1), 0);

    // R8: completion while disabled is dropped
    rd(a_clm(1), d); chk("R6 ctx1 claim", d, 32'd3);
    wr(a_en(1), 0); wr(a_clm(1), 3); wr(a_en(1), 32'h8); idle(2);
    chk("R8 ignored completion", 32'(irq[1]), 32'd0);
    wr(a_clm(1), 3); idle(2);
    chk("R7 completion rearms", 32'(irq[1]), 32'd1);
    rd(a_clm(0), d); chk("R6 shared claim ctx0", d, 32'd3);
    idle(1);
    chk("R6 claim clears for other ctx", 32'(irq[1]), 32'd0);

    // R5 R1: priority 0 masks
    wr(a_prio(3), 0); wr(a_clm(0), 3); idle(2);
    chk("R5 prio0 masked", 32'(irq), 32'd0);
    rd(a_clm(1), d); chk("R1 claim none", d, 32'd0);
    wr(a_prio(3), 1); idle(1);
    chk("R5 prio1 live", 32'(irq[1]), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule